// File: doc/BRIEF.md
# Dynamic Hazard Scoreboard for Multi-Unit Dispatch

This block is the central hazard controller for a small out-of-order core. It has five functional units: one integer unit, two floating multipliers, one floating adder and one divider. Decoded instructions arrive in program order and are accepted one per cycle. After that, each instruction waits for its source operands, executes and writes back independently of the others. The block owns three things: the stage each in-flight instruction has reached, a status record per unit, and a table that maps every architectural register to the unit that will produce its next value.

A decoded instruction is held on the issue inputs until `iss_accept` is high. The scoreboard names the unit it picked on `iss_unit`. A one-cycle pulse on `rd_grant[u]` tells unit `u` to read its operands from the register file and start. When the unit finishes, it pulses `exec_done[u]`. The scoreboard then raises `wr_grant[u]` once writing the result would not destroy a value that an older instruction still has to read. `wr_reg` names the register being written. Results are never forwarded: a consumer reads only after the producer's write.

Top module: `sb_scoreboard`

## Requirements
- R1: While reset is held, `iss_accept`, `rd_grant`, `wr_grant`, `wr_reg` and `fu_stage` are all zero, and no register has a pending producer.
- R2: Unit classes are coded on `iss_class` as 0 integer, 1 multiply, 2 add, 3 divide. The units are numbered 0 integer, 1 and 2 multiply, 3 add, 4 divide. An accepted instruction goes to the lowest-numbered idle unit of its class, shown on `iss_unit`. If no unit of that class is idle, `iss_accept` stays low (a structural stall).
- R3: `iss_accept` is high only when `iss_valid` is high and no in-flight instruction has the same destination register (a WAW stall). A stalled instruction stays at the head, so nothing behind it is accepted.
- R4: At issue, each source is recorded as waiting on the unit that currently owns that register, or as ready if no unit owns it. The new instruction becomes the owner of its destination register.
- R5: `rd_grant[u]` pulses exactly once per instruction. The earliest pulse is the cycle after issue. It pulses only when neither source has an older producer that has not yet written.
- R6: An `exec_done[u]` pulse in cycle t, for a unit that is executing, makes that unit eligible to write from cycle t+1 on.
- R7: An eligible unit is held off writing while any other busy unit has a source equal to this destination that is ready but not yet read. This includes the cycle in which that reader is granted (a WAR stall).
- R8: At most one `wr_grant` bit is high per cycle, the lowest-numbered eligible unit wins, and `wr_reg` carries that unit's destination register (zero when there is no write).
- R9: A write frees the unit and clears ownership of its destination, so the unit and a same-destination instruction may be accepted in the next cycle.
- R10: `fu_stage[2u+1:2u]` reports unit u as 0 idle, 1 waiting for operands, 2 executing, 3 complete and waiting to write.
- R11: `fu_op[OP_W*u +: OP_W]` carries the operation code of the instruction held by unit u while that unit is busy.
- R12: A write result becomes visible to operand-read decisions one cycle later. A source whose producer writes in the very cycle the consumer issues is recorded as ready, not as waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_class | input | 2 | Unit class required (0 int, 1 mul, 2 add, 3 div) |
| iss_op | input | OP_W | Operation code to hand to the unit |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_accept | output | 1 | Instruction taken this cycle |
| iss_unit | output | UIDX_W | Unit chosen for the accepted instruction |
| rd_grant | output | NUM_FU | Per-unit operand-read permission pulse |
| exec_done | input | NUM_FU | Per-unit execution-finished pulse |
| wr_grant | output | NUM_FU | Per-unit write-result permission pulse |
| wr_reg | output | REG_W | Register written this cycle |
| fu_stage | output | 2*NUM_FU | Per-unit stage code |
| fu_op | output | OP_W*NUM_FU | Per-unit held operation code |

## Verification
Two cases are hard to reach from the ports: a write held back by a pending reader, and a producer writing in the same cycle a consumer issues. Both need a long-latency producer that overlaps with a reader and a writer of the same register. The stimulus starts with a fixed dependent sequence in which an add writes a register that a stalled divide still has to read. Three independent multiplies and a repeated destination follow. A long stream of instructions then drawn at random over only eight registers, with random idle gaps, makes the same-cycle write/issue and multi-writer collisions occur many times. A behavioural model of each instruction's issue, read, done and write cycles is checked against every output on every clock.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        CL_INT = 2'd0,
        CL_MUL = 2'd1,
        CL_ADD = 2'd2,
        CL_DIV = 2'd3
    } class_e;

    // unit numbering: integer first, then the multipliers, then add, then divide
    function automatic logic [1:0] unit_class(input int idx, input int num_mul);
        if (idx == 0)                 return CL_INT;
        else if (idx <= num_mul)      return CL_MUL;
        else if (idx == num_mul + 1)  return CL_ADD;
        else                          return CL_DIV;
    endfunction

endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel #(
    parameter int NUM_MUL = 2,
    parameter int NUM_FU  = NUM_MUL + 3,
    parameter int UIDX_W  = $clog2(NUM_FU)
) (
    input  logic [NUM_FU-1:0] busy,
    input  logic [1:0]        cls,
    output logic              found,
    output logic [UIDX_W-1:0] idx
);
    import sb_pkg::*;

    // scan downward so the lowest matching idle unit is the last assignment
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (!busy[i] && unit_class(i, NUM_MUL) == cls) begin
                found = 1'b1;
                idx   = UIDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sb_rd_ctl.sv
module sb_rd_ctl #(
    parameter int NUM_FU = 5
) (
    input  logic [NUM_FU-1:0] waiting,
    input  logic [NUM_FU-1:0] rj,
    input  logic [NUM_FU-1:0] rk,
    output logic [NUM_FU-1:0] grant
);
    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        assign grant[u] = waiting[u] & rj[u] & rk[u];
    end

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
    parameter int NUM_FU = 5,
    parameter int REG_W  = 5,
    parameter int UIDX_W = $clog2(NUM_FU)
) (
    input  logic [NUM_FU-1:0]            req,
    input  logic [NUM_FU-1:0]            busy,
    input  logic [NUM_FU-1:0]            rj,
    input  logic [NUM_FU-1:0]            rk,
    input  logic [NUM_FU-1:0][REG_W-1:0] fi,
    input  logic [NUM_FU-1:0][REG_W-1:0] fj,
    input  logic [NUM_FU-1:0][REG_W-1:0] fk,
    output logic [NUM_FU-1:0]            grant,
    output logic                         any,
    output logic [UIDX_W-1:0]            idx
);
    logic [NUM_FU-1:0] blocked;

    // a pending, not yet read source equal to this destination holds the write
    for (genvar u = 0; u < NUM_FU; u++) begin : g_war
        always_comb begin
            blocked[u] = 1'b0;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != u && busy[f] &&
                    ((fj[f] == fi[u] && rj[f]) || (fk[f] == fi[u] && rk[f])))
                    blocked[u] = 1'b1;
            end
        end
    end

    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        for (int u = NUM_FU - 1; u >= 0; u--) begin
            if (req[u] && !blocked[u]) begin
                any = 1'b1;
                idx = UIDX_W'(u);
            end
        end
        if (any) grant[idx] = 1'b1;
    end

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
    parameter int NUM_REGS = 32,
    parameter int NUM_MUL  = 2,
    parameter int OP_W     = 4,
    parameter int NUM_FU   = NUM_MUL + 3,
    parameter int REG_W    = $clog2(NUM_REGS),
    parameter int UIDX_W   = $clog2(NUM_FU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_valid,
    input  logic [1:0]             iss_class,
    input  logic [OP_W-1:0]        iss_op,
    input  logic [REG_W-1:0]       iss_dst,
    input  logic [REG_W-1:0]       iss_src1,
    input  logic [REG_W-1:0]       iss_src2,
    output logic                   iss_accept,
    output logic [UIDX_W-1:0]      iss_unit,
    output logic [NUM_FU-1:0]      rd_grant,
    input  logic [NUM_FU-1:0]      exec_done,
    output logic [NUM_FU-1:0]      wr_grant,
    output logic [REG_W-1:0]       wr_reg,
    output logic [2*NUM_FU-1:0]    fu_stage,
    output logic [OP_W*NUM_FU-1:0] fu_op
);
    import sb_pkg::*;

    // producer tag: 0 means no pending writer, unit u is tag u+1
    localparam int TAG_W = $clog2(NUM_FU + 1);

    typedef struct packed {
        logic             busy;
        stage_e           stage;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        logic [TAG_W-1:0] qj;
        logic [TAG_W-1:0] qk;
        logic             rj;
        logic             rk;
    } fu_rec_t;

    typedef struct packed {
        fu_rec_t [NUM_FU-1:0]              fu;
        logic [NUM_REGS-1:0][TAG_W-1:0]    owner;
    } sb_state_t;

    sb_state_t st_d, st_q;

    logic [NUM_FU-1:0]            busy_v, rj_v, rk_v, wait_v, done_v;
    logic [NUM_FU-1:0][REG_W-1:0] fi_v, fj_v, fk_v;
    logic                         free_found;
    logic [UIDX_W-1:0]            free_idx;
    logic                         wr_any;
    logic [UIDX_W-1:0]            wr_idx;
    logic [TAG_W-1:0]             wr_tag;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            busy_v[u] = st_q.fu[u].busy;
            rj_v[u]   = st_q.fu[u].rj;
            rk_v[u]   = st_q.fu[u].rk;
            wait_v[u] = st_q.fu[u].stage == ST_WAIT;
            done_v[u] = st_q.fu[u].stage == ST_DONE;
            fi_v[u]   = st_q.fu[u].fi;
            fj_v[u]   = st_q.fu[u].fj;
            fk_v[u]   = st_q.fu[u].fk;
        end
    end

    sb_issue_sel #(.NUM_MUL(NUM_MUL), .NUM_FU(NUM_FU), .UIDX_W(UIDX_W)) u_sel (
        .busy  (busy_v),
        .cls   (iss_class),
        .found (free_found),
        .idx   (free_idx)
    );

    sb_rd_ctl #(.NUM_FU(NUM_FU)) u_rd (
        .waiting (wait_v),
        .rj      (rj_v),
        .rk      (rk_v),
        .grant   (rd_grant)
    );

    sb_wb_arb #(.NUM_FU(NUM_FU), .REG_W(REG_W), .UIDX_W(UIDX_W)) u_wb (
        .req   (done_v),
        .busy  (busy_v),
        .rj    (rj_v),
        .rk    (rk_v),
        .fi    (fi_v),
        .fj    (fj_v),
        .fk    (fk_v),
        .grant (wr_grant),
        .any   (wr_any),
        .idx   (wr_idx)
    );

    assign wr_tag     = TAG_W'(wr_idx) + TAG_W'(1);
    assign iss_accept = iss_valid && free_found && (st_q.owner[iss_dst] == '0);
    assign iss_unit   = free_idx;
    assign wr_reg     = wr_any ? st_q.fu[wr_idx].fi : '0;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            fu_stage[2*u +: 2]    = st_q.fu[u].stage;
            fu_op[OP_W*u +: OP_W] = st_q.fu[u].op;
        end
    end

    always_comb begin
        fu_rec_t nrec;
        st_d = st_q;
        nrec = '0;

        // write result: wake consumers, release register and unit
        if (wr_any) begin
            for (int f = 0; f < NUM_FU; f++) begin
                if (st_q.fu[f].qj == wr_tag) begin
                    st_d.fu[f].rj = 1'b1;
                    st_d.fu[f].qj = '0;
                end
                if (st_q.fu[f].qk == wr_tag) begin
                    st_d.fu[f].rk = 1'b1;
                    st_d.fu[f].qk = '0;
                end
            end
            st_d.owner[st_q.fu[wr_idx].fi] = '0;
            st_d.fu[wr_idx].busy  = 1'b0;
            st_d.fu[wr_idx].stage = ST_IDLE;
            st_d.fu[wr_idx].rj    = 1'b0;
            st_d.fu[wr_idx].rk    = 1'b0;
            st_d.fu[wr_idx].qj    = '0;
            st_d.fu[wr_idx].qk    = '0;
        end

        // read operands: consume ready flags, start execution
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant[u]) begin
                st_d.fu[u].stage = ST_EXEC;
                st_d.fu[u].rj    = 1'b0;
                st_d.fu[u].rk    = 1'b0;
            end
        end

        // execution complete
        for (int u = 0; u < NUM_FU; u++) begin
            if (exec_done[u] && st_q.fu[u].stage == ST_EXEC)
                st_d.fu[u].stage = ST_DONE;
        end

        // issue: fill the record, a producer writing now counts as done
        if (iss_accept) begin
            nrec.busy  = 1'b1;
            nrec.stage = ST_WAIT;
            nrec.op    = iss_op;
            nrec.fi    = iss_dst;
            nrec.fj    = iss_src1;
            nrec.fk    = iss_src2;
            nrec.qj    = st_q.owner[iss_src1];
            nrec.qk    = st_q.owner[iss_src2];
            if (wr_any && nrec.qj == wr_tag) nrec.qj = '0;
            if (wr_any && nrec.qk == wr_tag) nrec.qk = '0;
            nrec.rj    = nrec.qj == '0;
            nrec.rk    = nrec.qk == '0;
            st_d.fu[free_idx]     = nrec;
            st_d.owner[iss_dst]   = TAG_W'(free_idx) + TAG_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
    parameter int NUM_FU = 5,
    parameter int UIDX_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic                 iss_accept,
    input logic [UIDX_W-1:0]    iss_unit,
    input logic [NUM_FU-1:0]    rd_grant,
    input logic [NUM_FU-1:0]    exec_done,
    input logic [NUM_FU-1:0]    wr_grant,
    input logic [2*NUM_FU-1:0]  fu_stage
);
    a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));

    a_r3_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> iss_valid);

    a_r2_issue_into_idle: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> fu_stage[2*iss_unit +: 2] == 2'd0);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        a_r5_grant_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |-> fu_stage[2*u +: 2] == 2'd1);

        a_r5_grant_starts_exec: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> fu_stage[2*u +: 2] == 2'd2);

        a_r6_done_completes: assert property (@(posedge clk) disable iff (!rst_n)
            (exec_done[u] && fu_stage[2*u +: 2] == 2'd2) |=> fu_stage[2*u +: 2] == 2'd3);

        a_r7_write_from_complete: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[u] |-> fu_stage[2*u +: 2] == 2'd3);

        a_r9_write_frees_unit: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[u] |=> fu_stage[2*u +: 2] == 2'd0);
    end

endmodule

bind sb_scoreboard sb_scoreboard_chk #(.NUM_FU(NUM_FU), .UIDX_W(UIDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_accept (iss_accept),
    .iss_unit   (iss_unit),
    .rd_grant   (rd_grant),
    .exec_done  (exec_done),
    .wr_grant   (wr_grant),
    .fu_stage   (fu_stage)
);

// File: tb/tb_sb_scoreboard.sv
module tb_sb_scoreboard;
    localparam int NM = 2;
    localparam int NF = NM + 3;
    localparam int OPW = 4;
    localparam int RW = 5;
    localparam int UW = 3;
    localparam int NI = 320;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             iss_valid;
    logic [1:0]       iss_class;
    logic [OPW-1:0]   iss_op;
    logic [RW-1:0]    iss_dst, iss_src1, iss_src2;
    logic             iss_accept;
    logic [UW-1:0]    iss_unit;
    logic [NF-1:0]    rd_grant, exec_done, wr_grant;
    logic [RW-1:0]    wr_reg;
    logic [2*NF-1:0]  fu_stage;
    logic [OPW*NF-1:0] fu_op;

    sb_scoreboard dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_accept(iss_accept), .iss_unit(iss_unit), .rd_grant(rd_grant),
        .exec_done(exec_done), .wr_grant(wr_grant), .wr_reg(wr_reg),
        .fu_stage(fu_stage), .fu_op(fu_op)
    );

    int p_cls[NI], p_op[NI], p_dst[NI], p_s1[NI], p_s2[NI], p_gap[NI];
    int r_unit[NI], r_iss[NI], r_rd[NI], r_done[NI], r_wr[NI];
    int n_prog = 0;
    int n_cmp = 0, n_bad = 0;

    function automatic int lat_of(int c);
        case (c)
            0: return 1;
            1: return 10;
            2: return 2;
            default: return 40;
        endcase
    endfunction

    function automatic int lo_unit(int c);
        case (c)
            0: return 0;
            1: return 1;
            2: return NM + 1;
            default: return NM + 2;
        endcase
    endfunction

    function automatic int hi_unit(int c);
        return (c == 1) ? NM : lo_unit(c);
    endfunction

    task automatic add_ins(int c, int op, int d, int a, int b, int g);
        p_cls[n_prog] = c; p_op[n_prog] = op; p_dst[n_prog] = d;
        p_s1[n_prog] = a; p_s2[n_prog] = b; p_gap[n_prog] = g;
        r_unit[n_prog] = -1; r_iss[n_prog] = -1; r_rd[n_prog] = -1;
        r_done[n_prog] = -1; r_wr[n_prog] = -1;
        n_prog++;
    endtask

    task automatic chk(string tag, int act, int exp, int cyc);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    initial begin
        int pc, gap_left, n_written;
        int occ[NF];
        int sel;
        logic exp_acc;
        logic [NF-1:0] exp_rd, exp_wr;
        int exp_wreg;

        rst_n = 1'b0; iss_valid = 1'b0; iss_class = '0; iss_op = '0;
        iss_dst = '0; iss_src1 = '0; iss_src2 = '0; exec_done = '0;

        // dependent sequence with a WAR hold on register 6 (add waits for the divide read)
        add_ins(0, 1, 6, 2, 2, 0);
        add_ins(0, 1, 2, 3, 3, 0);
        add_ins(1, 2, 0, 2, 4, 0);
        add_ins(2, 3, 8, 6, 2, 0);
        add_ins(3, 4, 10, 0, 6, 0);
        add_ins(2, 5, 6, 8, 2, 0);
        // structural: third independent multiply waits for a free multiplier
        add_ins(1, 6, 12, 13, 14, 0);
        add_ins(1, 7, 15, 13, 14, 0);
        add_ins(1, 8, 16, 13, 14, 0);
        // WAW: integer op to the divide's destination stalls until that write
        add_ins(3, 9, 20, 21, 22, 3);
        add_ins(0, 10, 20, 1, 1, 0);
        add_ins(0, 11, 21, 20, 20, 0);
        while (n_prog < NI)
            add_ins($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 7),
                    $urandom_range(0, 7), $urandom_range(0, 7),
                    ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 accept in reset", int'(iss_accept), 0, 0);
        chk("R1 rd_grant in reset", int'(rd_grant), 0, 0);
        chk("R1 wr_grant in reset", int'(wr_grant), 0, 0);
        chk("R1 wr_reg in reset", int'(wr_reg), 0, 0);
        chk("R1 stage in reset", int'(fu_stage), 0, 0);
        rst_n = 1'b1;

        pc = 0; gap_left = p_gap[0]; n_written = 0;
        for (int c = 1; ; c++) begin
            @(posedge clk);
            #1;
            exec_done = '0;
            for (int i = 0; i < pc; i++)
                if (r_done[i] == c) exec_done[r_unit[i]] = 1'b1;
            if (pc < n_prog && gap_left == 0) begin
                iss_valid = 1'b1;
                iss_class = 2'(p_cls[pc]); iss_op = OPW'(p_op[pc]);
                iss_dst = RW'(p_dst[pc]); iss_src1 = RW'(p_s1[pc]); iss_src2 = RW'(p_s2[pc]);
            end else begin
                iss_valid = 1'b0;
                if (gap_left > 0) gap_left--;
            end
            #2;

            for (int u = 0; u < NF; u++) occ[u] = -1;
            for (int i = 0; i < pc; i++)
                if (r_wr[i] < 0) occ[r_unit[i]] = i;

            // stage and op per unit (R10, R6, R11)
            for (int u = 0; u < NF; u++) begin
                int es;
                if (occ[u] < 0) es = 0;
                else if (r_rd[occ[u]] < 0) es = 1;
                else if (r_done[occ[u]] >= c) es = 2;
                else es = 3;
                chk("R10/R6 stage", int'(fu_stage[2*u +: 2]), es, c);
                if (es != 0) chk("R11 op", int'(fu_op[OPW*u +: OPW]), p_op[occ[u]], c);
            end

            // issue (R2, R3, R9)
            exp_acc = 1'b0; sel = -1;
            if (iss_valid) begin
                for (int u = hi_unit(p_cls[pc]); u >= lo_unit(p_cls[pc]); u--)
                    if (occ[u] < 0) sel = u;
                exp_acc = (sel >= 0);
                for (int i = 0; i < pc; i++)
                    if (r_wr[i] < 0 && p_dst[i] == p_dst[pc]) exp_acc = 1'b0;
            end
            chk("R2/R3/R9 accept", int'(iss_accept), int'(exp_acc), c);
            if (exp_acc) chk("R2 unit", int'(iss_unit), sel, c);

            // operand read (R4, R5, R12)
            exp_rd = '0;
            for (int u = 0; u < NF; u++) begin
                int id;
                id = occ[u];
                if (id >= 0 && r_rd[id] < 0) begin
                    logic ok;
                    ok = 1'b1;
                    for (int j = 0; j < id; j++)
                        if (r_wr[j] < 0 && (p_dst[j] == p_s1[id] || p_dst[j] == p_s2[id])) ok = 1'b0;
                    exp_rd[u] = ok;
                end
            end
            chk("R4/R5/R12 rd_grant", int'(rd_grant), int'(exp_rd), c);

            // write result (R6, R7, R8)
            exp_wr = '0; exp_wreg = 0;
            for (int u = NF - 1; u >= 0; u--) begin
                int id;
                id = occ[u];
                if (id >= 0 && r_rd[id] >= 0 && r_done[id] < c) begin
                    logic ok;
                    ok = 1'b1;
                    for (int k = 0; k < id; k++)
                        if (r_wr[k] < 0 && r_rd[k] < 0 &&
                            (p_s1[k] == p_dst[id] || p_s2[k] == p_dst[id])) ok = 1'b0;
                    if (ok) begin
                        exp_wr = '0; exp_wr[u] = 1'b1; exp_wreg = p_dst[id];
                    end
                end
            end
            chk("R7/R8 wr_grant", int'(wr_grant), int'(exp_wr), c);
            chk("R8 wr_reg", int'(wr_reg), exp_wreg, c);

            // advance the model with its own decisions
            for (int u = 0; u < NF; u++) begin
                if (exp_rd[u]) begin
                    r_rd[occ[u]] = c;
                    r_done[occ[u]] = c + lat_of(p_cls[occ[u]]);
                end
                if (exp_wr[u]) begin
                    r_wr[occ[u]] = c;
                    n_written++;
                end
            end
            if (exp_acc) begin
                r_unit[pc] = sel; r_iss[pc] = c;
                pc++;
                if (pc < n_prog) gap_left = p_gap[pc];
            end

            if (n_written == n_prog) break;
            if (c > 150000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog cycle %0d: actual=%0d expected=%0d written", c, n_written, n_prog);
                break;
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule